// File: doc/BRIEF.md
# Packed-Result Integer Divider

A sequential integer divider that takes a double-width dividend and a single-width divisor and returns the quotient and the remainder packed together in one word, plus an overflow flag. It has two operand widths. In narrow mode a 2N-bit dividend is divided by an N-bit divisor. In wide mode a 4N-bit dividend is divided by a 2N-bit divisor. N is the parameter `NARROW_W`, default 8, which gives 16/8 and 32/16 division. A separate input selects unsigned or signed (two's complement) arithmetic. Narrow-mode operands sit in the low bits of the `dividend` and `divisor` ports.

The core uses restoring shift-subtract division on operand magnitudes and resolves one quotient bit per clock. It applies the signs after the last step. A zero divisor is detected when the operation is accepted. It finishes at once with a fixed fill pattern: the dividend's halves are swapped and the moved upper half is inverted.

Control is a three-state machine with states IDLE, RUN and WRAP:
- IDLE goes to RUN on an accepted start with a nonzero divisor.
- IDLE stays in IDLE on an accepted start with a zero divisor; the result is written directly.
- RUN counts down the quotient bits and goes to WRAP after the last bit.
- WRAP applies the signs, registers the packed result, pulses `done` and returns to IDLE.

Top module: `packed_divider`

## Requirements
- R1: Narrow mode packs the quotient's low N bits into result[N-1:0] and the remainder's low N bits into result[2N-1:N]. Result bits 4N-1:2N are zero.
- R2: Wide mode packs the quotient's low 2N bits into result[2N-1:0] and the remainder's low 2N bits into result[4N-1:2N].
- R3: In unsigned mode, `ovf` is 1 exactly when the full quotient exceeds 2^N-1 (narrow) or 2^2N-1 (wide). The truncated quotient and the remainder are still packed.
- R4: Signed mode (`signed_mode`=1) truncates the quotient toward zero, and the remainder carries the sign of the dividend.
- R5: In signed mode, `ovf` is 1 only when the quotient is positive and greater than 2^N-1 (narrow) or 2^2N-1 (wide). A negative quotient never sets `ovf`.
- R6: A zero divisor (low N bits in narrow mode, all 2N bits in wide mode) sets `ovf` to 1 in either signedness.
  - Narrow mode gives result = {zeros, dividend[N-1:0], ~dividend[2N-1:N]}.
  - Wide mode gives result = {dividend[2N-1:0], ~dividend[4N-1:2N]}.
  - `done` rises at the accepting clock edge.
- R7: With a nonzero divisor, `done` rises at the clock edge K+1 edges after the accepting edge, where K=2N in narrow mode and K=4N in wide mode. `busy` is 1 from the accepting edge until `done` rises.
- R8: A start while `busy` is 1 is ignored. The running operation completes with its own operands.
- R9: `done` is a one-cycle pulse. `result` and `ovf` change only at an edge that raises `done`.
- R10: After reset, `busy`, `done`, `ovf` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; accepted only while not busy |
| wide_mode | input | 1 | 1 selects 4N/2N division, 0 selects 2N/N |
| signed_mode | input | 1 | 1 selects two's complement operands |
| dividend | input | 4N | Dividend; narrow mode uses bits 2N-1:0 |
| divisor | input | 2N | Divisor; narrow mode uses bits N-1:0 |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 4N | Packed remainder (upper half) and quotient (lower half) |
| ovf | output | 1 | Overflow / divide-by-zero flag |

## Verification
The bench builds the divider with `NARROW_W`=4, which makes narrow mode an 8-bit by 4-bit divide. That size lets the bench sweep every dividend and divisor pair in narrow mode, in both signednesses. The sweep covers every zero-divisor pattern and the most-negative-by-minus-one case, and exercises every quotient bit position and every overflow boundary. Wide mode (16 by 8) is covered by a pseudo-random sample plus chosen corner operands. A separate sequence checks the reset values, a start issued mid-operation, and output holding after `done`.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WRAP
    } div_state_e;

    typedef struct packed {
        logic wide;
        logic neg_q;
        logic neg_r;
    } div_ctl_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int NARROW_W = 8
) (
    input  logic [4*NARROW_W-1:0] dividend,
    input  logic [2*NARROW_W-1:0] divisor,
    input  logic                  wide,
    input  logic                  sgn,
    output logic [4*NARROW_W-1:0] q_init,
    output logic [2*NARROW_W-1:0] dvs_mag,
    output logic                  neg_q,
    output logic                  neg_r,
    output logic                  dvs_zero,
    output logic [4*NARROW_W-1:0] zero_fill
);
    localparam int DVW = 2 * NARROW_W;
    localparam int DDW = 4 * NARROW_W;

    logic [DVW-1:0]      nd_raw;
    logic [NARROW_W-1:0] nv_raw;
    logic                nd_neg, nv_neg, wd_neg, wv_neg;
    logic [DVW-1:0]      nd_mag;
    logic [NARROW_W-1:0] nv_mag;
    logic [DDW-1:0]      wd_mag;
    logic [DVW-1:0]      wv_mag;

    always_comb begin
        nd_raw = dividend[DVW-1:0];
        nv_raw = divisor[NARROW_W-1:0];
        nd_neg = sgn & nd_raw[DVW-1];
        nv_neg = sgn & nv_raw[NARROW_W-1];
        wd_neg = sgn & dividend[DDW-1];
        wv_neg = sgn & divisor[DVW-1];
        nd_mag = nd_neg ? -nd_raw : nd_raw;
        nv_mag = nv_neg ? -nv_raw : nv_raw;
        wd_mag = wd_neg ? -dividend : dividend;
        wv_mag = wv_neg ? -divisor : divisor;

        if (wide) begin
            q_init    = wd_mag;
            dvs_mag   = wv_mag;
            neg_q     = wd_neg ^ wv_neg;
            neg_r     = wd_neg;
            dvs_zero  = (divisor == '0);
            zero_fill = {dividend[DVW-1:0], ~dividend[DDW-1:DVW]};
        end else begin
            q_init    = {nd_mag, {DVW{1'b0}}};
            dvs_mag   = {{NARROW_W{1'b0}}, nv_mag};
            neg_q     = nd_neg ^ nv_neg;
            neg_r     = nd_neg;
            dvs_zero  = (nv_raw == '0);
            zero_fill = {{DVW{1'b0}}, dividend[NARROW_W-1:0], ~dividend[DVW-1:NARROW_W]};
        end
    end
endmodule

// File: rtl/div_shift_core.sv
module div_shift_core #(
    parameter int NARROW_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic [4*NARROW_W-1:0] q_init,
    input  logic [2*NARROW_W-1:0] dvs_in,
    output logic [4*NARROW_W-1:0] quo_mag,
    output logic [2*NARROW_W-1:0] rem_mag
);
    localparam int DVW = 2 * NARROW_W;
    localparam int DDW = 4 * NARROW_W;

    logic [DDW-1:0] q_reg;
    logic [DVW-1:0] r_reg;
    logic [DVW-1:0] d_reg;
    logic [DVW:0]   trial;
    logic [DVW:0]   diff;
    logic           fits;

    always_comb begin
        trial = {r_reg, q_reg[DDW-1]};
        diff  = trial - {1'b0, d_reg};
        fits  = (trial >= {1'b0, d_reg});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_reg <= '0;
            r_reg <= '0;
            d_reg <= '0;
        end else if (load) begin
            q_reg <= q_init;
            r_reg <= '0;
            d_reg <= dvs_in;
        end else if (step) begin
            q_reg <= {q_reg[DDW-2:0], fits};
            r_reg <= fits ? diff[DVW-1:0] : trial[DVW-1:0];
        end
    end

    assign quo_mag = q_reg;
    assign rem_mag = r_reg;
endmodule

// File: rtl/div_result_pack.sv
module div_result_pack
    import div_pkg::*;
#(
    parameter int NARROW_W = 8
) (
    input  logic [4*NARROW_W-1:0] quo_mag,
    input  logic [2*NARROW_W-1:0] rem_mag,
    input  div_ctl_t              ctl,
    output logic [4*NARROW_W-1:0] packed_word,
    output logic                  packed_ovf
);
    localparam int DVW = 2 * NARROW_W;
    localparam int DDW = 4 * NARROW_W;

    logic [DDW-1:0] quo_s;
    logic [DVW-1:0] rem_s;
    logic           too_big;

    always_comb begin
        quo_s   = ctl.neg_q ? -quo_mag : quo_mag;
        rem_s   = ctl.neg_r ? -rem_mag : rem_mag;
        too_big = ctl.wide ? (|quo_mag[DDW-1:DVW]) : (|quo_mag[DDW-1:NARROW_W]);
        packed_ovf = too_big & ~ctl.neg_q;
        if (ctl.wide)
            packed_word = {rem_s, quo_s[DVW-1:0]};
        else
            packed_word = {{DVW{1'b0}}, rem_s[NARROW_W-1:0], quo_s[NARROW_W-1:0]};
    end
endmodule

// File: rtl/packed_divider.sv
module packed_divider
    import div_pkg::*;
#(
    parameter int NARROW_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  wide_mode,
    input  logic                  signed_mode,
    input  logic [4*NARROW_W-1:0] dividend,
    input  logic [2*NARROW_W-1:0] divisor,
    output logic                  busy,
    output logic                  done,
    output logic [4*NARROW_W-1:0] result,
    output logic                  ovf
);
    localparam int DVW   = 2 * NARROW_W;
    localparam int DDW   = 4 * NARROW_W;
    localparam int CNT_W = $clog2(DDW + 1);

    div_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    div_ctl_t       ctl_q;

    logic [DDW-1:0] q_init, zero_fill, quo_mag, packed_word;
    logic [DVW-1:0] dvs_mag, rem_mag;
    logic           neg_q, neg_r, dvs_zero, packed_ovf;
    logic           accept, launch, stepping;

    div_operand_prep #(.NARROW_W(NARROW_W)) u_prep (
        .dividend  (dividend),
        .divisor   (divisor),
        .wide      (wide_mode),
        .sgn       (signed_mode),
        .q_init    (q_init),
        .dvs_mag   (dvs_mag),
        .neg_q     (neg_q),
        .neg_r     (neg_r),
        .dvs_zero  (dvs_zero),
        .zero_fill (zero_fill)
    );

    div_shift_core #(.NARROW_W(NARROW_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (launch),
        .step    (stepping),
        .q_init  (q_init),
        .dvs_in  (dvs_mag),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag)
    );

    div_result_pack #(.NARROW_W(NARROW_W)) u_pack (
        .quo_mag     (quo_mag),
        .rem_mag     (rem_mag),
        .ctl         (ctl_q),
        .packed_word (packed_word),
        .packed_ovf  (packed_ovf)
    );

    assign accept   = start && (state_q == ST_IDLE);
    assign launch   = accept && !dvs_zero;
    assign stepping = (state_q == ST_RUN);
    assign busy     = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == CNT_W'(1)) state_d = ST_WRAP;
            ST_WRAP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ctl_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q <= wide_mode ? CNT_W'(DDW) : CNT_W'(DVW);
                ctl_q <= '{wide: wide_mode, neg_q: neg_q, neg_r: neg_r};
            end else if (stepping) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
            ovf    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept && dvs_zero) begin
                done   <= 1'b1;
                result <= zero_fill;
                ovf    <= 1'b1;
            end else if (state_q == ST_WRAP) begin
                done   <= 1'b1;
                result <= packed_word;
                ovf    <= packed_ovf;
            end
        end
    end
endmodule

// File: rtl/packed_divider_chk.sv
module packed_divider_chk #(
    parameter int NARROW_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  wide_mode,
    input logic [2*NARROW_W-1:0] divisor,
    input logic                  busy,
    input logic                  done,
    input logic [4*NARROW_W-1:0] result,
    input logic                  ovf,
    input logic                  wide_q
);
    localparam int DVW = 2 * NARROW_W;
    localparam int DDW = 4 * NARROW_W;

    logic past_ok;
    logic zero_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign zero_in = wide_mode ? (divisor == '0) : (divisor[NARROW_W-1:0] == '0);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !done) |-> ($stable(result) && $stable(ovf)));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R6
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && zero_in) |=> (done && ovf && !busy));

    // R1
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide_q) |-> (result[DDW-1:DVW] == '0));
endmodule

bind packed_divider packed_divider_chk #(.NARROW_W(NARROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wide_mode (wide_mode),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .ovf       (ovf),
    .wide_q    (ctl_q.wide)
);

// File: tb/packed_divider_tb.sv
module packed_divider_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide_mode = 1'b0;
    logic        signed_mode = 1'b0;
    logic [15:0] dividend = '0;
    logic [7:0]  divisor = '0;
    logic        busy, done, ovf;
    logic [15:0] result;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    packed_divider #(.NARROW_W(NW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .wide_mode   (wide_mode),
        .signed_mode (signed_mode),
        .dividend    (dividend),
        .divisor     (divisor),
        .busy        (busy),
        .done        (done),
        .result      (result),
        .ovf         (ovf)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [15:0] dd, input logic [7:0] dv, input bit wide, input bit sgn,
                         output logic [15:0] res, output bit v, output bit zero);
        int a, b, q, r, lim;
        if (wide) begin
            a = sgn ? int'($signed(dd)) : int'(dd);
            b = sgn ? int'($signed(dv)) : int'(dv);
            lim = 255;
        end else begin
            a = sgn ? int'($signed(dd[7:0])) : int'(dd[7:0]);
            b = sgn ? int'($signed(dv[3:0])) : int'(dv[3:0]);
            lim = 15;
        end
        zero = (b == 0);
        if (zero) begin
            v   = 1'b1;
            res = wide ? {dd[7:0], ~dd[15:8]} : {8'h00, dd[3:0], ~dd[7:4]};
        end else begin
            q = a / b;
            r = a % b;
            v = (q > lim);
            res = wide ? {r[7:0], q[7:0]} : {8'h00, r[3:0], q[3:0]};
        end
    endtask

    task automatic run_one(input logic [15:0] dd, input logic [7:0] dv, input bit wide, input bit sgn);
        logic [15:0] exp_res;
        bit          exp_v, zero;
        int          cnt, exp_cnt;
        string       tag, vtag;
        model(dd, dv, wide, sgn, exp_res, exp_v, zero);
        if (zero)      tag = "R6";
        else if (sgn)  tag = "R4";
        else if (wide) tag = "R2";
        else           tag = "R1";
        vtag = zero ? "R6" : (sgn ? "R5" : "R3");
        exp_cnt = zero ? 1 : (wide ? 4*NW + 2 : 2*NW + 2);
        @(negedge clk);
        dividend = dd; divisor = dv; wide_mode = wide; signed_mode = sgn; start = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            cnt++;
        end while (!done && cnt < 40);
        check(result == exp_res, tag, 32'(result), 32'(exp_res));
        check(ovf == exp_v, vtag, 32'(ovf), 32'(exp_v));
        check(cnt == exp_cnt, "R7 latency", 32'(cnt), 32'(exp_cnt));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] held;
        int          cnt;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(busy == 1'b0 && done == 1'b0 && ovf == 1'b0 && result == '0, "R10 reset",
              {15'd0, busy, done, ovf, result[13:0]}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // narrow mode exhaustive, both signednesses
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < 256; d++)
                for (int v = 0; v < 16; v++)
                    run_one(16'(d), 8'(v), 1'b0, s[0]);

        // wide mode corners
        run_one(16'h8000, 8'hFF, 1'b1, 1'b1);
        run_one(16'hFFFF, 8'h01, 1'b1, 1'b0);
        run_one(16'h00FF, 8'h01, 1'b1, 1'b0);
        run_one(16'h0100, 8'h01, 1'b1, 1'b0);
        run_one(16'h7F80, 8'h80, 1'b1, 1'b1);
        run_one(16'h1234, 8'h00, 1'b1, 1'b1);
        run_one(16'hABCD, 8'h00, 1'b1, 1'b0);
        // wide mode random sample
        for (int i = 0; i < 1200; i++) begin
            logic [15:0] rd = 16'($urandom);
            if (i % 3 == 0) rd = {8'h00, rd[7:0]};
            run_one(rd, 8'($urandom), 1'b1, i[0]);
        end

        // R8: start while busy is ignored (200/7 -> q=28 r=4, packed 0x004C, ovf=1)
        @(negedge clk);
        dividend = 16'd200; divisor = 8'd7; wide_mode = 1'b0; signed_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7 busy", 32'(busy), 32'd1);
        @(negedge clk);
        dividend = 16'd9; divisor = 8'd3; wide_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 3;
        while (!done && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        check(result == 16'h004C, "R8 result", 32'(result), 32'h004C);
        check(ovf == 1'b1, "R8 ovf", 32'(ovf), 32'd1);
        check(cnt == 2*NW + 2, "R8 latency", 32'(cnt), 32'(2*NW + 2));

        // R9: done is a single pulse and the result holds
        held = result;
        repeat (5) @(negedge clk);
        check(done == 1'b0, "R9 pulse", 32'(done), 32'd0);
        check(result == held && ovf == 1'b1, "R9 hold", 32'(result), 32'(held));
        check(busy == 1'b0, "R8 no restart", 32'(busy), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule